// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a byte-wide nonvolatile memory. A host writes bytes through a synchronous strobe made of three enable levels. The block gathers one to sixty-four bytes of a single page into a staging buffer. The first accepted byte locks the page. Each later byte of that page restarts a load window. When the window runs out with no new byte, the block starts a self-timed programming cycle. At the end of that cycle it copies the staged bytes into an internal byte array and returns to idle.

Reads are served straight from the array with one cycle of latency. The read side is a plain request/valid pair. It has no back-pressure: every read request produces a valid result on the next cycle. The write side has no ready signal either. A byte offered while the block is programming is dropped, and the host learns this from the busy output. Both timing windows are parameters counted in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: A write strobe exists only while `sel_i`=1, `wr_i`=1 and `oe_i`=0. Any other combination, including `oe_i`=1 with both others high, loads nothing and starts no programming.
- R2: The address is taken in the first cycle of a strobe. The data is taken in the first cycle after the strobe condition goes false. Address changes later in the strobe are ignored, and the data value must still be held in that release cycle.
- R3: `addr_i[5:0]` selects the byte within a page. The bits above bit 5 select the page. Any offset 0 to 63 of any page can be written and read back.
- R4: `busy_o` rises exactly LOAD_WIN cycles after the clock edge that accepted the most recent byte, provided no further byte is accepted in that time. Each accepted byte restarts the window.
- R5: During a load, a strobe whose page differs from the locked page is ignored. It neither writes its byte nor restarts the window.
- R6: `busy_o` stays high for exactly PROG_CYC cycles. When it falls, every loaded byte of the page holds its new value, and the unloaded bytes of the page keep their old values.
- R7: Strobes that begin while `busy_o` is high are discarded. They change no byte and start no new load.
- R8: A read request (`sel_i`=1, `oe_i`=1, `wr_i`=0) gives `rd_vld_o`=1 and the array byte at `addr_i` on the next cycle. During a load, reads return the old array contents.
- R9: After reset, `busy_o`=0 and `rd_vld_o`=0.
- R10: When the same offset is loaded twice within one page operation, the later byte is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select level |
| wr_i | input | 1 | Write enable level |
| oe_i | input | 1 | Output (read) enable level |
| addr_i | input | ADDR_W | Byte address: page above bit 5, offset in bits 5:0 |
| data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, valid with rd_vld_o |
| rd_vld_o | output | 1 | Read result valid |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
A table of single-byte page writes covers first and last offsets and low, middle and top pages. This separates a correct offset/page split from a swapped or truncated one. Timed multi-byte loads tell the two window cases apart: a matching second byte pushes the start of programming out by a full window, while a byte for a foreign page leaves the start of programming unchanged. Other stimuli change the address and data inside one strobe, hold output enable high during a write, write while busy, and load the same offset twice. These show which sample point is used and which writes are dropped. Reads issued during a load show that the staged bytes do not reach the array before the commit.

// File: rtl/plc_pkg.sv
`timescale 1ns/1ps
package plc_pkg;
  typedef enum logic [1:0] {
    PLC_IDLE = 2'd0,
    PLC_LOAD = 2'd1,
    PLC_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_down_cnt.sv
`timescale 1ns/1ps
module plc_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/plc_page_buf.sv
`timescale 1ns/1ps
module plc_page_buf #(
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << OFS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [OFS_W-1:0]             wr_off_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         clr_i,
  output logic [PAGE_BYTES*DATA_W-1:0] bytes_o,
  output logic [PAGE_BYTES-1:0]        mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (wr_en_i && (wr_off_i == OFS_W'(g))) begin
        byte_q <= wr_data_i;
        vld_q  <= 1'b1;
      end
    end

    assign bytes_o[g*DATA_W +: DATA_W] = byte_q;
    assign mask_o[g]                   = vld_q;
  end
endmodule

// File: rtl/page_load_ctrl.sv
`timescale 1ns/1ps
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 6,
  parameter int LOAD_WIN = 25000,
  parameter int PROG_CYC = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              busy_o
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WIN_W      = $clog2(LOAD_WIN + 1);
  localparam int PRG_W      = $clog2(PROG_CYC + 1);

  plc_state_e state_q;

  logic              strobe, strobe_q, st_rise, st_fall;
  logic [PAGE_W-1:0] page_in, lock_q;
  logic [OFS_W-1:0]  off_in, off_q;
  logic              pend_q, load_ok, expire, commit;
  logic              win_zero, prog_zero, rd_req;

  logic [PAGE_BYTES*DATA_W-1:0] page_bytes;
  logic [PAGE_BYTES-1:0]        page_mask;
  logic [DATA_W-1:0]            mem [DEPTH];
  logic [DATA_W-1:0]            rd_data_q;
  logic                         rd_vld_q;

  // strobe edges
  assign strobe  = sel_i & wr_i & ~oe_i;
  assign st_rise = strobe & ~strobe_q;
  assign st_fall = ~strobe & strobe_q;
  assign page_in = addr_i[ADDR_W-1:OFS_W];
  assign off_in  = addr_i[OFS_W-1:0];
  assign rd_req  = sel_i & oe_i & ~wr_i;

  assign load_ok = st_rise &&
                   ((state_q == PLC_IDLE) ||
                    ((state_q == PLC_LOAD) && (page_in == lock_q)));
  assign expire  = (state_q == PLC_LOAD) && win_zero && !pend_q && !load_ok;
  assign commit  = (state_q == PLC_PROG) && prog_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PLC_IDLE;
      strobe_q <= 1'b0;
      pend_q   <= 1'b0;
      lock_q   <= '0;
      off_q    <= '0;
    end else begin
      strobe_q <= strobe;
      if (load_ok) begin
        pend_q <= 1'b1;
        off_q  <= off_in;
        if (state_q == PLC_IDLE) lock_q <= page_in;
      end else if (st_fall) begin
        pend_q <= 1'b0;
      end
      case (state_q)
        PLC_IDLE: if (load_ok) state_q <= PLC_LOAD;
        PLC_LOAD: if (expire)  state_q <= PLC_PROG;
        PLC_PROG: if (commit)  state_q <= PLC_IDLE;
        default:               state_q <= PLC_IDLE;
      endcase
    end
  end

  plc_down_cnt #(.CNT_W(WIN_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_ok),
    .load_val_i (WIN_W'(LOAD_WIN - 1)),
    .zero_o     (win_zero)
  );

  plc_down_cnt #(.CNT_W(PRG_W)) u_prog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (expire),
    .load_val_i (PRG_W'(PROG_CYC - 1)),
    .zero_o     (prog_zero)
  );

  plc_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (st_fall & pend_q),
    .wr_off_i  (off_q),
    .wr_data_i (data_i),
    .clr_i     (commit),
    .bytes_o   (page_bytes),
    .mask_o    (page_mask)
  );

  // array: commit on the last programming cycle, reads see old contents
  always_ff @(posedge clk_i) begin
    if (commit) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (page_mask[k]) mem[{lock_q, OFS_W'(k)}] <= page_bytes[k*DATA_W +: DATA_W];
      end
    end
    if (rd_req) rd_data_q <= mem[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_req;
  end

  assign rd_data_o = rd_data_q;
  assign rd_vld_o  = rd_vld_q;
  assign busy_o    = (state_q == PLC_PROG);
endmodule

// File: rtl/plc_chk.sv
`timescale 1ns/1ps
module plc_chk #(
  parameter int LOAD_WIN = 8,
  parameter int PROG_CYC = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic load_ok_i,
  input logic any_byte_i,
  input logic rd_req_i,
  input logic rd_vld_i
);
  logic [31:0] gap_q, blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      blen_q <= '0;
    end else begin
      if (load_ok_i)            gap_q <= 32'd1;
      else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
      blen_q <= busy_i ? blen_q + 1'b1 : '0;
    end
  end

  a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (gap_q >= 32'(LOAD_WIN)));

  a_r6_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (blen_q == 32'(PROG_CYC)));

  a_r6_has_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> any_byte_i);

  a_r8_rd_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_vld_i);

  a_r8_rd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_vld_i);
endmodule

bind page_load_ctrl plc_chk #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .load_ok_i  (load_ok),
  .any_byte_i (|page_mask),
  .rd_req_i   (sel_i & oe_i & ~wr_i),
  .rd_vld_i   (rd_vld_o)
);

// File: tb/page_load_ctrl_tb.sv
`timescale 1ns/1ps
module page_load_ctrl_tb;
  localparam int AW = 10;
  localparam int W  = 8;
  localparam int P  = 20;
  localparam int NV = 8;
  localparam logic [AW-1:0] VA [NV] = '{10'h000, 10'h03F, 10'h040, 10'h3FF,
                                        10'h155, 10'h2AA, 10'h1C0, 10'h07E};
  localparam logic [7:0]    VD [NV] = '{8'h5A, 8'hC3, 8'h01, 8'hFE,
                                        8'h80, 8'h7F, 8'h33, 8'hE7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, rdat;
  logic rvld, busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(8), .OFS_W(6), .LOAD_WIN(W), .PROG_CYC(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .oe_i(oe),
    .addr_i(addr), .data_i(din), .rd_data_o(rdat), .rd_vld_o(rvld), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; oe = 0; addr = a; din = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); sel = 1; wr = 0; oe = 1; addr = a;
    @(negedge clk); sel = 0; oe = 0; d = rdat; v = rvld;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] e);
    logic [7:0] d; logic v;
    rd_byte(a, d, v);
    chk({tag, " valid"}, int'(v), 1);
    chk(tag, int'(d), int'(e));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic count_to_busy(output int n);
    n = 0;
    for (int i = 0; i < 200 && !busy; i++) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int n, seen;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 rd_vld after reset", int'(rvld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 vector table: single byte pages
    for (int i = 0; i < NV; i++) begin
      wr_byte(VA[i], VD[i]);
      wait_idle();
      rd_chk("R3 table readback", VA[i], VD[i]);
    end

    // R4 window length, R6 busy length
    wr_byte(10'h140, 8'hA5);
    count_to_busy(n);
    chk("R4 cycles to busy", n, W);
    seen = 0;
    for (int i = 0; i < 200 && busy; i++) begin seen++; @(negedge clk); end
    chk("R6 busy length", seen, P);
    rd_chk("R6 committed byte", 10'h140, 8'hA5);

    // prewrite bytes used later
    wr_byte(10'h152, 8'h99); wait_idle();
    wr_byte(10'h185, 8'h66); wait_idle();

    // R4 retrigger by matching page
    wr_byte(10'h150, 8'h11);
    wr_byte(10'h151, 8'h22);
    count_to_busy(n);
    chk("R4 retrigger window", n, W);
    wait_idle();
    rd_chk("R4 first byte", 10'h150, 8'h11);
    rd_chk("R4 second byte", 10'h151, 8'h22);
    rd_chk("R6 unloaded byte kept", 10'h152, 8'h99);

    // R5 mismatched page, R8 read during load
    wr_byte(10'h160, 8'h33);
    wr_byte(10'h185, 8'h77);
    rd_chk("R8 read during load old data", 10'h185, 8'h66);
    count_to_busy(n);
    chk("R5 mismatch no restart", n, W - 4);
    wait_idle();
    rd_chk("R5 mismatch byte ignored", 10'h185, 8'h66);
    rd_chk("R5 locked page byte", 10'h160, 8'h33);

    // R7 writes while busy are dropped
    wr_byte(10'h200, 8'hC3);
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    wr_byte(10'h200, 8'hFF);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    seen = 0;
    for (int i = 0; i < W + 5; i++) begin @(negedge clk); if (busy) seen++; end
    chk("R7 no load from busy write", seen, 0);
    rd_chk("R7 byte kept", 10'h200, 8'hC3);

    // R1 blocked strobes
    @(negedge clk); sel = 1; wr = 1; oe = 1; addr = 10'h200; din = 8'h00;
    @(negedge clk); @(negedge clk); oe = 0; sel = 0;
    @(negedge clk); sel = 1; wr = 0;
    @(negedge clk); sel = 0;
    seen = 0;
    for (int i = 0; i < W + 5; i++) begin @(negedge clk); if (busy) seen++; end
    chk("R1 blocked strobes start nothing", seen, 0);
    rd_chk("R1 byte unchanged", 10'h200, 8'hC3);

    // R2 address at start, data at release
    @(negedge clk); sel = 1; wr = 1; oe = 0; addr = 10'h2C0; din = 8'h01;
    @(negedge clk); addr = 10'h2C1; din = 8'h02;
    @(negedge clk); sel = 0; wr = 0; din = 8'h03;
    @(negedge clk); din = 8'h04;
    wait_idle();
    rd_chk("R2 capture points", 10'h2C0, 8'h03);

    // R10 same offset twice
    wr_byte(10'h300, 8'h10);
    wr_byte(10'h300, 8'h20);
    wait_idle();
    rd_chk("R10 later byte wins", 10'h300, 8'h20);

    done = 1'b1;
    finish_run();
  end
endmodule